// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block sits between a display controller's byte stream and its pixel memory. Each accepted data byte is placed at the current position of a rectangular write window. The byte goes out on a memory write port in the same cycle, and the position then moves on to the next cell of the window. The memory is organised as byte columns by rows, with two 4-bit pixels in each byte, and the byte address is `column + row * COLS`.

The window is set through two load strobes: one for columns and one for rows. Each strobe carries a first and a last value, reduced modulo the axis size. A level input selects the scan order. In column-first order the column advances first and the row moves on at the end of a line. In row-first order the row advances first and the column moves on at the bottom of the window. Both axes wrap back to their start value on their own. A sticky redraw flag records that the memory has changed since the last display refresh. Command decoding and the memory array itself are outside this block.

Top module: `fb_win_addr_gen`

## Requirements
- R1: In any cycle with `wr_valid` high, `mem_we` is high, `mem_wdata` equals `wr_data`, and `mem_addr` equals `column + row * COLS` for the current position. All of these are combinational in that same cycle. `mem_we` is low when `wr_valid` is low.
- R2: After reset the window spans columns 0 to COLS-1 and rows 0 to ROWS-1, and the position is column 0, row 0. With the defaults, successive writes from reset therefore land at addresses 0, 1, 2, ... and cross from address 63 to address 64.
- R3: With `row_first` low, each write advances the column by one. When the incremented column would exceed the column end, the column returns to the column start and the row advances. A row that would exceed the row end returns to the row start.
- R4: With `row_first` high, each write advances the row by one. When the incremented row would exceed the row end, the row returns to the row start and the column advances. A column that would exceed the column end returns to the column start.
- R5: A `col_load` pulse sets the current column and the column start to `win_first mod COLS`, and sets the column end to `win_last mod COLS`. The new values take effect from the next cycle.
- R6: A `row_load` pulse sets the current row and the row start to `win_first mod ROWS`, and sets the row end to `win_last mod ROWS`. The new values take effect from the next cycle.
- R7: If an axis start is greater than its end, or equal to it, every advance on that axis returns it to its start value.
- R8: `redraw_pend` goes high in the cycle after a write. `refresh_done` without a write clears it one cycle later. When a write and `refresh_done` arrive in the same cycle, the flag ends up set. The flag is 0 after reset.
- R9: When a load strobe and a write arrive in the same cycle, the write uses the old address. The loaded axis takes its new values, and that write causes no position advance.
- R10: Without a write or a load, the position does not change, and this holds even while `row_first` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A data byte is offered in this cycle |
| wr_data | input | 8 | Data byte (two 4-bit pixels) |
| row_first | input | 1 | 1 = row-first scan order, 0 = column-first |
| col_load | input | 1 | Load the column window from win_first/win_last |
| row_load | input | 1 | Load the row window from win_first/win_last |
| win_first | input | 8 | Window start value, reduced modulo axis size |
| win_last | input | 8 | Window end value, reduced modulo axis size |
| refresh_done | input | 1 | Display refresh finished; clears the redraw flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 13 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| redraw_pend | output | 1 | Memory changed since the last refresh |

## Verification
The hardest situations to reach are the two wraps inside one advance: a column wrap that also forces a row wrap, or the reverse in row-first order. Next to these is a load strobe that collides with a write. The stimulus loads small windows of two cells by two, so that both nested wraps come round within a few bytes, in each scan order. It also loads windows whose start is greater than or equal to their end, and the one-cell window at the last address of memory. It then pulses a load in the same cycle as a write and reads the effect from the following write addresses.

// File: rtl/fbw_pkg.sv
// Shared definitions for the windowed framebuffer write address generator.
// Assumes: axis sizes fit in 32-bit arithmetic.
package fbw_pkg;

    // Scan order selected by the row_first input.
    typedef enum logic {
        ORDER_COL_FIRST = 1'b0,
        ORDER_ROW_FIRST = 1'b1
    } scan_order_e;

    // Reduce a raw window value into the range of an axis.
    function automatic int unsigned axis_reduce(input int unsigned raw, input int unsigned size);
        return raw % size;
    endfunction

endpackage

// File: rtl/fbw_axis.sv
// One axis (column or row) of the write window.
// Holds the start, end and current position of the axis. A load replaces all
// three from reduced input values. A step moves the position by one, returning
// it to the start when it would pass the end.
// Assumes: load and step are never both acted on (load wins by priority here).
module fbw_axis #(
    parameter int unsigned SIZE = 64,
    parameter int unsigned IN_W = 8,
    localparam int unsigned W   = $clog2(SIZE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [IN_W-1:0] first,
    input  logic [IN_W-1:0] last,
    input  logic            step,
    output logic [W-1:0]    cur,
    output logic            wrap
);
    import fbw_pkg::*;

    logic [W-1:0] start_q;
    logic [W-1:0] end_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] first_m;
    logic [W-1:0] last_m;
    logic [W:0]   cur_inc;

    // Reduce the incoming window bounds modulo the axis size.
    always_comb begin
        first_m = W'(axis_reduce(32'(first), SIZE));
        last_m  = W'(axis_reduce(32'(last), SIZE));
    end

    // Incremented position and whether it passes the window end.
    always_comb begin
        cur_inc = {1'b0, cur_q} + 1'b1;
        wrap    = cur_inc > {1'b0, end_q};
    end

    // Window bounds and position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= W'(SIZE - 1);
            cur_q   <= '0;
        end else if (load) begin
            start_q <= first_m;
            end_q   <= last_m;
            cur_q   <= first_m;
        end else if (step) begin
            cur_q   <= wrap ? start_q : cur_inc[W-1:0];
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/fbw_step_ctrl.sv
// Decides which axes advance after an accepted byte.
// The primary axis steps on every advancing write, and the secondary axis
// steps only when the primary wraps. Any load in the same cycle cancels the
// advance.
// Assumes: wrap inputs describe the current position, before this edge.
module fbw_step_ctrl (
    input  logic               wr_valid,
    input  logic               any_load,
    input  fbw_pkg::scan_order_e order,
    input  logic               col_wrap,
    input  logic               row_wrap,
    output logic               col_step,
    output logic               row_step
);
    import fbw_pkg::*;

    logic advance;

    // Select primary and secondary axis from the scan order.
    always_comb begin
        advance = wr_valid && !any_load;
        if (order == ORDER_ROW_FIRST) begin
            row_step = advance;
            col_step = advance && row_wrap;
        end else begin
            col_step = advance;
            row_step = advance && col_wrap;
        end
    end

endmodule

// File: rtl/fbw_redraw.sv
// Sticky flag that marks the framebuffer as changed since the last refresh.
// Assumes: set has priority over clear when both are seen in one cycle.
module fbw_redraw (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic flag
);
    // Set on a write, clear on a refresh, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end

endmodule

// File: rtl/fb_win_addr_gen.sv
// Windowed framebuffer write address generator (top).
// Presents each accepted byte on the memory port at the current window
// position in the same cycle, then advances the position in column-first or
// row-first order. Both axes wrap independently inside their windows.
// Assumes: COLS*ROWS cells, one byte each, address = col + row*COLS.
module fb_win_addr_gen #(
    parameter int unsigned COLS   = 64,
    parameter int unsigned ROWS   = 80,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WIN_W  = 8,
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned ADDR_W = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              row_first,
    input  logic              col_load,
    input  logic              row_load,
    input  logic [WIN_W-1:0]  win_first,
    input  logic [WIN_W-1:0]  win_last,
    input  logic              refresh_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              redraw_pend
);
    import fbw_pkg::*;

    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic             col_wrap;
    logic             row_wrap;
    logic             col_step;
    logic             row_step;
    scan_order_e      order;

    // Map the level input onto the scan order type.
    always_comb order = row_first ? ORDER_ROW_FIRST : ORDER_COL_FIRST;

    fbw_axis #(.SIZE(COLS), .IN_W(WIN_W)) u_col_axis (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (col_load),
        .first (win_first),
        .last  (win_last),
        .step  (col_step),
        .cur   (cur_col),
        .wrap  (col_wrap)
    );

    fbw_axis #(.SIZE(ROWS), .IN_W(WIN_W)) u_row_axis (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (row_load),
        .first (win_first),
        .last  (win_last),
        .step  (row_step),
        .cur   (cur_row),
        .wrap  (row_wrap)
    );

    fbw_step_ctrl u_step (
        .wr_valid (wr_valid),
        .any_load (col_load || row_load),
        .order    (order),
        .col_wrap (col_wrap),
        .row_wrap (row_wrap),
        .col_step (col_step),
        .row_step (row_step)
    );

    fbw_redraw u_redraw (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wr_valid),
        .clear (refresh_done),
        .flag  (redraw_pend)
    );

    // Address composition: concatenation for a power-of-two width, else multiply-add.
    generate
        if ((1 << COL_W) == COLS) begin : g_addr_concat
            assign mem_addr = ADDR_W'({cur_row, cur_col});
        end else begin : g_addr_mul
            assign mem_addr = ADDR_W'(cur_row) * ADDR_W'(COLS) + ADDR_W'(cur_col);
        end
    endgenerate

    // Memory write port driven straight from the accepted byte.
    always_comb begin
        mem_we    = wr_valid;
        mem_wdata = wr_data;
    end

endmodule

// Property checker for the address generator.
module fbw_checker #(
    parameter int unsigned COLS   = 64,
    parameter int unsigned ROWS   = 80,
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              col_load,
    input logic              row_load,
    input logic              row_first,
    input logic              refresh_done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              redraw_pend,
    input logic              col_wrap,
    input logic              row_wrap
);
    localparam int unsigned CELLS = COLS * ROWS;

    assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(mem_addr) < CELLS));

    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !col_load && !row_load && !row_first && !col_wrap)
        |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !col_load && !row_load && row_first && !row_wrap)
        |=> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(COLS)));

    assert_redraw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> redraw_pend);

    assert_redraw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && !wr_valid) |=> !redraw_pend);

    assert_collide_keep_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && row_load && !col_load)
        |=> (mem_addr % ADDR_W'(COLS)) == ($past(mem_addr) % ADDR_W'(COLS)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !col_load && !row_load) |=> $stable(mem_addr));

endmodule

bind fb_win_addr_gen fbw_checker #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_fbw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .col_load     (col_load),
    .row_load     (row_load),
    .row_first    (row_first),
    .refresh_done (refresh_done),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .redraw_pend  (redraw_pend),
    .col_wrap     (col_wrap),
    .row_wrap     (row_wrap)
);

// File: tb/test_fb_win_addr_gen.sv
module test_fb_win_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        row_first = 1'b0;
    logic        col_load = 1'b0;
    logic        row_load = 1'b0;
    logic [7:0]  win_first = 8'h00;
    logic [7:0]  win_last = 8'h00;
    logic        refresh_done = 1'b0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        redraw_pend;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fb_win_addr_gen i_fb_win_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .row_first(row_first), .col_load(col_load), .row_load(row_load),
        .win_first(win_first), .win_last(win_last), .refresh_done(refresh_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .redraw_pend(redraw_pend)
    );

    // Vector: op(2) p1(8) p2(8) expected address(13).
    // op 0 = write (expect address), 1 = load columns, 2 = load rows, 3 = set row_first = p1[0].
    localparam int NVEC = 23;
    localparam logic [30:0] VEC [0:NVEC-1] = '{
        {2'd0, 8'h11, 8'd0,   13'd0},    // R2 reset position
        {2'd0, 8'h22, 8'd0,   13'd1},    // R3
        {2'd1, 8'd2,  8'd3,   13'd0},    // R5 columns 2..3
        {2'd2, 8'd5,  8'd6,   13'd0},    // R6 rows 5..6
        {2'd0, 8'h33, 8'd0,   13'd322},  // R5 R6 new origin
        {2'd0, 8'h44, 8'd0,   13'd323},  // R3
        {2'd0, 8'h55, 8'd0,   13'd386},  // R3 column wrap, row step
        {2'd0, 8'h66, 8'd0,   13'd387},  // R3
        {2'd0, 8'h77, 8'd0,   13'd322},  // R3 both wrap
        {2'd3, 8'd1,  8'd0,   13'd0},    // R4 row-first
        {2'd0, 8'h88, 8'd0,   13'd323},  // R4
        {2'd0, 8'h99, 8'd0,   13'd387},  // R4
        {2'd0, 8'hAA, 8'd0,   13'd322},  // R4 both wrap
        {2'd0, 8'hBB, 8'd0,   13'd386},  // R4
        {2'd0, 8'hCC, 8'd0,   13'd323},  // R4 row wrap, column step
        {2'd3, 8'd0,  8'd0,   13'd0},    // column-first again
        {2'd1, 8'd200, 8'd70, 13'd0},    // R5 R7 start 8 > end 6
        {2'd2, 8'd170, 8'd250,13'd0},    // R6 R7 start 10 == end 10
        {2'd0, 8'hDD, 8'd0,   13'd648},  // R7
        {2'd0, 8'hEE, 8'd0,   13'd648},  // R7 both return to start
        {2'd1, 8'd63, 8'd255, 13'd0},    // R5 end 255 mod 64 = 63
        {2'd2, 8'd79, 8'd79,  13'd0},    // R6 last row
        {2'd0, 8'hFF, 8'd0,   13'd5119}  // R7 last cell
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; address and data sampled mid-cycle before the edge.
    task automatic do_write(input logic [7:0] d, input int exp, input string req);
        wr_valid = 1'b1;
        wr_data  = d;
        #1;
        chk(req, int'(mem_addr), exp);
        chk("R1 mem_we", int'(mem_we), 1);
        chk("R1 mem_wdata", int'(mem_wdata), int'(d));
        @(posedge clk); #1;
        wr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load(input bit rows, input logic [7:0] a, input logic [7:0] b);
        win_first = a;
        win_last  = b;
        if (rows) row_load = 1'b1; else col_load = 1'b1;
        #1;
        chk("R1 no strobe on load", int'(mem_we), 0);
        @(posedge clk); #1;
        col_load = 1'b0;
        row_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R2, R8).
        chk("R2 reset addr", int'(mem_addr), 0);
        chk("R8 reset redraw", int'(redraw_pend), 0);
        chk("R1 reset we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][30:29])
                2'd0: do_write(VEC[i][28:21], int'(VEC[i][12:0]), $sformatf("R3 R4 R7 vec %0d addr", i));
                2'd1: do_load(1'b0, VEC[i][28:21], VEC[i][20:13]);
                2'd2: do_load(1'b1, VEC[i][28:21], VEC[i][20:13]);
                default: begin row_first = VEC[i][21]; @(negedge clk); end
            endcase
        end

        // R8: flag set by writes, cleared by refresh, set wins on collision.
        chk("R8 set after writes", int'(redraw_pend), 1);
        refresh_done = 1'b1;
        @(posedge clk); #1; refresh_done = 1'b0; @(negedge clk);
        chk("R8 cleared by refresh", int'(redraw_pend), 0);
        refresh_done = 1'b1;
        do_write(8'h5A, 5119, "R7 last cell again");
        refresh_done = 1'b0;
        chk("R8 write beats refresh", int'(redraw_pend), 1);

        // R9: loads colliding with writes.
        do_load(1'b0, 8'd0, 8'd63);
        do_load(1'b1, 8'd0, 8'd79);
        do_write(8'h01, 0, "R5 R6 full window origin");
        win_first = 8'd20; win_last = 8'd30; col_load = 1'b1;
        do_write(8'h02, 1, "R9 col collision uses old addr");
        col_load = 1'b0;
        do_write(8'h03, 20, "R9 col loaded, no advance");
        win_first = 8'd3; win_last = 8'd9; row_load = 1'b1;
        do_write(8'h04, 21, "R9 row collision uses old addr");
        row_load = 1'b0;
        do_write(8'h05, 213, "R9 row loaded, column kept");

        // R10: idle cycles and order toggles leave the position alone.
        row_first = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 idle hold", int'(mem_addr), 214);
        row_first = 1'b0;
        @(negedge clk);
        chk("R10 order toggle hold", int'(mem_addr), 214);

        // R2: mid-run reset restores full window; 65 writes cross into row 1.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 reset addr again", int'(mem_addr), 0);
        chk("R8 reset clears redraw", int'(redraw_pend), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 65; k++) begin
            do_write(8'(k), k, "R2 R3 reset window sweep");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule